// File: doc/BRIEF.md
# Two-Stage Pipelined Split-Carry Adder

This block adds two 32-bit operands and a carry-in. It produces a 32-bit sum and a carry-out, and accepts a new operand pair on every clock. The carry chain is cut at the midpoint of the word, so that no single cycle has to ripple through the full width.

The operands and the carry-in are first captured in an input register. In the following cycle the lower half-width slice adds the low halves with the captured carry-in. Its sum and carry-out are registered, and the high halves of the operands are registered alongside them.

In the cycle after that, the upper slice adds the delayed high halves using the registered carry. The upper sum and the final carry-out are registered together with a second copy of the low sum, so the whole result leaves in one cycle. An input valid flag travels through the same three register levels and marks each result.

Top module: `split_add_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears every pipeline register. Afterwards `out_valid`, `sum_out` and `carry_out` all read 0.
- R2: The outputs hold `{carry_out, sum_out}` equal to `op_a + op_b + carry_in`, computed at full width plus one bit. Bit 32 of that total is `carry_out`.
- R3: Inputs sampled at rising edge k appear on the outputs just after rising edge k+2. `out_valid` shows the `in_valid` sampled at edge k with the same timing.
- R4: A carry generated by bits 15:0 is added into bit 16 of the result, including the case where it ripples through the whole upper half into `carry_out`.
- R5: A different operand pair may be presented at every rising edge, with no idle cycles. Each result appears in order, exactly two edges after its own capture edge.
- R6: `carry_in` adds one at bit 0. With all-ones operands and zeros, that one wraps `sum_out` to 0 and sets `carry_out`.
- R7: When `in_valid` is 0 at capture edge k, `out_valid` is 0 after edge k+2, whatever the operand values were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand pair presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 32 | Registered sum |
| carry_out | output | 1 | Registered carry out of bit 31 |
| out_valid | output | 1 | Marks the result on `sum_out`/`carry_out` as valid |

## Verification
A wrong low-half carry register, or high operands misaligned by a cycle, shows as an upper half off by one. It can also show as an upper half belonging to the neighbouring operand pair. Either way the fault appears in the very result that crosses bit 16, two edges after its capture.

A missing low-sum alignment stage pairs one pair's low half with the next pair's high half. So back-to-back streams with distinct operands expose it at once. A broken valid delay shows as `out_valid` leading or lagging a bubble by one cycle.

// File: rtl/split_add_pipe.sv
module split_add_pipe #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out,
  output logic              out_valid
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] a_cap, b_cap;
  logic              cin_cap, v_cap;

  logic [LO_W-1:0]   lo_sum_q;
  logic              lo_carry_q;
  logic [HI_W-1:0]   hi_a_q, hi_b_q;
  logic              v_mid;

  logic [LO_W:0]     lo_total;
  logic [HI_W:0]     hi_total;

  assign lo_total = {1'b0, a_cap[LO_W-1:0]} + {1'b0, b_cap[LO_W-1:0]} + {{LO_W{1'b0}}, cin_cap};
  assign hi_total = {1'b0, hi_a_q} + {1'b0, hi_b_q} + {{HI_W{1'b0}}, lo_carry_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap   <= '0;
      b_cap   <= '0;
      cin_cap <= 1'b0;
      v_cap   <= 1'b0;
    end else begin
      a_cap   <= op_a;
      b_cap   <= op_b;
      cin_cap <= carry_in;
      v_cap   <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_sum_q   <= '0;
      lo_carry_q <= 1'b0;
      hi_a_q     <= '0;
      hi_b_q     <= '0;
      v_mid      <= 1'b0;
    end else begin
      lo_sum_q   <= lo_total[LO_W-1:0];
      lo_carry_q <= lo_total[LO_W];
      hi_a_q     <= a_cap[DATA_W-1:LO_W];
      hi_b_q     <= b_cap[DATA_W-1:LO_W];
      v_mid      <= v_cap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      carry_out <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      sum_out   <= {hi_total[HI_W-1:0], lo_sum_q};
      carry_out <= hi_total[HI_W];
      out_valid <= v_mid;
    end
  end
endmodule

// File: rtl/split_add_pipe_checker.sv
module split_add_pipe_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              carry_in,
  input logic [DATA_W-1:0] sum_out,
  input logic              carry_out,
  input logic              out_valid
);
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && sum_out == '0 && !carry_out));

  // R2, R4, R5, R6: the sum of the pair captured two edges earlier
  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> ({carry_out, sum_out} ==
      ({1'b0, $past(op_a, 3)} + {1'b0, $past(op_b, 3)} + {{DATA_W{1'b0}}, $past(carry_in, 3)})));

  p_valid_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$past(in_valid, 3)) |-> !out_valid);
endmodule

bind split_add_pipe split_add_pipe_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/split_add_pipe_bench.sv
module split_add_pipe_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [31:0] sum_out;
  logic        carry_out, out_valid;

  int checks = 0;
  int errors = 0;

  logic        h_known [3];
  logic        h_valid [3];
  logic [32:0] h_total [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  split_add_pipe u_split_add_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum_out(sum_out), .carry_out(carry_out), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic forget();
    for (int i = 0; i < 3; i++) h_known[i] = 1'b0;
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic c, input string req);
    @(negedge clk);
    if (h_known[2]) begin
      check({req, " R3 valid"}, {32'd0, out_valid}, {32'd0, h_valid[2]});
      if (h_valid[2]) check(req, {carry_out, sum_out}, h_total[2]);
    end
    for (int i = 2; i > 0; i--) begin
      h_known[i] = h_known[i-1];
      h_valid[i] = h_valid[i-1];
      h_total[i] = h_total[i-1];
    end
    h_known[0] = 1'b1;
    h_valid[0] = v;
    h_total[0] = {1'b0, a} + {1'b0, b} + {32'd0, c};
    in_valid = v; op_a = a; op_b = b; carry_in = c;
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < 3; i++) step(1'b0, 32'd0, 32'd0, 1'b0, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'h1; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", {carry_out, sum_out}, 33'd0);
    check("R1 reset valid", {32'd0, out_valid}, 33'd0);
    rst = 1'b0;
    in_valid = 1'b0; op_a = '0; op_b = '0; carry_in = 1'b0;
    forget();
  endtask

  task automatic t_latency();
    step(1'b1, 32'h0000_1234, 32'h0000_0001, 1'b0, "R3");
    step(1'b0, 32'd0, 32'd0, 1'b0, "R3");
    @(negedge clk);
    check("R3 not yet", {32'd0, out_valid}, 33'd0);
    @(posedge clk); #1;
    check("R3 after k+2", {carry_out, sum_out}, 33'h0_0000_1235);
    check("R3 valid after k+2", {32'd0, out_valid}, 33'd1);
    forget();
    flush("R3");
  endtask

  task automatic t_mid_carry();
    step(1'b1, 32'h0000_FFFF, 32'h0000_0001, 1'b0, "R4");
    step(1'b1, 32'h7FFF_8000, 32'h0000_8000, 1'b0, "R4");
    step(1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R4");
    step(1'b1, 32'h0001_FFFF, 32'h0000_0000, 1'b1, "R4");
    flush("R4");
  endtask

  task automatic t_carry_in();
    step(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R6");
    step(1'b1, 32'h0000_0000, 32'h0000_0000, 1'b1, "R6");
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6");
    step(1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, "R2");
    flush("R6");
  endtask

  task automatic t_stream();
    logic [31:0] x = 32'h1357_9BDF;
    for (int i = 0; i < 40; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      step(1'b1, x, {x[15:0], x[31:16]} ^ 32'hA5A5_5A5A, x[7], "R5");
    end
    flush("R5");
  endtask

  task automatic t_bubbles();
    for (int i = 0; i < 12; i++)
      step(i % 3 != 1, 32'h0F0F_0000 + i, 32'h00F0_FFFF, i[0], "R7");
    flush("R7");
  endtask

  task automatic t_reset_midstream();
    step(1'b1, 32'h1111_1111, 32'h2222_2222, 1'b0, "R1");
    step(1'b1, 32'h3333_3333, 32'h4444_4444, 1'b1, "R1");
    t_reset();
    flush("R1");
  endtask

  initial begin
    forget();
    t_reset();
    t_latency();
    t_mid_carry();
    t_carry_in();
    t_stream();
    t_bubbles();
    t_reset_midstream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule